// File: doc/BRIEF.md
# Tanner-graph four-cycle probe

This block decides whether a candidate edge between bit node `i` and check node `j` of a low-density parity-check code would close a cycle of length four in the code's Tanner graph. The graph is held outside the block in two synchronous-read adjacency memories, filled before any query.

The first memory lists the bit neighbours of each check node. The second lists the check neighbours of each bit node. The block owns one read port into each memory. A query is made by pulsing `start` with the candidate pair. The block then walks the two-hop neighbourhood of `j` in a fixed nested order. It ends with a one-cycle `done` pulse and a `loop_found` flag, which holds until the next accepted query.

Both node counts and both degrees are parameters. The defaults describe a (3,6)-regular code with 1024 bit nodes and 512 check nodes. A parameter chooses between stopping on the first match and always walking the whole neighbourhood.

Top module: `tanner_quad_probe`

## Requirements
- R1: While reset is applied and right after it, `busy`, `done` and `loop_found` are all 0.
- R2: A `start` seen while the block is idle is accepted. It captures `cand_bit` and `cand_chk`. `busy` is 1 from the cycle after acceptance up to and including the `done` cycle, and 0 otherwise.
- R3: The walk uses three nested slot loops in ascending slot order: the outer loop over the slots of check `j`, the middle loop over the slots of bit `k`, and the inner loop over the slots of check `l`. Each memory read takes two cycles, one to issue and one to use the data. `done` is high in cycle 2·R+1 after the accepting edge, where R is the number of reads performed.
- R4: A bit neighbour `k` of check `j` that equals the candidate bit is skipped. Its check list is not read.
- R5: A check `l` that equals the candidate check is skipped. Its bit list is not read.
- R6: `loop_found` is 1 exactly when the candidate bit appears in the bit list of some visited check `l`. With early exit enabled (the default), the walk ends at the first such match.
- R7: `done` is a single-cycle pulse. `loop_found` is cleared when a query is accepted, is valid in the `done` cycle, and holds until the next accepted query.
- R8: A `start` pulse seen while `busy` is 1, including in the `done` cycle, is ignored. It does not change the captured candidate pair, the result or the timing.
- R9: Read addresses are formed as {node index, slot}. For the check-to-bit memory the slot field is the low clog2(CHK_DEG) bits (3 by default). For the bit-to-check memory it is the low clog2(BIT_DEG) bits (2 by default). Read data is returned on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Query request, sampled only while idle |
| cand_bit | input | clog2(NUM_BITS) | Candidate bit node index `i` |
| cand_chk | input | clog2(NUM_CHECKS) | Candidate check node index `j` |
| busy | output | 1 | Query in progress |
| done | output | 1 | One-cycle completion pulse |
| loop_found | output | 1 | A four-cycle would be closed |
| c2b_addr | output | clog2(NUM_CHECKS)+clog2(CHK_DEG) | Check-to-bit memory read address {check, slot} |
| c2b_data | input | clog2(NUM_BITS) | Check-to-bit memory read data (bit index) |
| b2c_addr | output | clog2(NUM_BITS)+clog2(BIT_DEG) | Bit-to-check memory read address {bit, slot} |
| b2c_data | input | clog2(NUM_CHECKS) | Bit-to-check memory read data (check index) |

## Verification
The hardest cases to reach from the ports are the two exclusion paths and the match in the very last slot. In a random graph a skipped `k` or `l` is rarely the only route back to the candidate bit, so faulty exclusion logic can give the right flag by chance. The bench therefore fills the memories with crafted graphs. In one, the only way back to `i` is through `k = i` or through `l = j`, so the correct answer is "no loop". In another, the single match sits in the final slot of every loop. Random graphs, with and without the candidate bit scrubbed from all check lists, cover the general case. Every query's flag and its exact latency are compared with a walk computed in the bench.

// File: rtl/tqp_pkg.sv
package tqp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_K_REQ,
      ST_K_USE,
      ST_L_REQ,
      ST_L_USE,
      ST_M_REQ,
      ST_M_USE,
      ST_DONE
   } probe_state_t;

   // Width of an index able to address n items (at least one bit).
   function automatic int idx_bits(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tqp_slot_ctr.sv
module tqp_slot_ctr #(
   parameter  int LEN = 6,
   localparam int IW  = tqp_pkg::idx_bits(LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [IW-1:0] idx,
   output logic          last
);

   logic [IW-1:0] idx_nxt;

   if (LEN < 2) begin : g_bad_len
      $error("tqp_slot_ctr: LEN must be at least 2");
   end

   // Power-of-two length wraps by itself; otherwise compare against the end.
   if (LEN == (1 << IW)) begin : g_pow2
      assign last    = &idx;
      assign idx_nxt = idx + 1'b1;
   end else begin : g_cmp
      assign last    = (idx == IW'(LEN - 1));
      assign idx_nxt = last ? '0 : idx + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (clr)   idx <= '0;
      else if (step)  idx <= idx_nxt;
   end

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !last) |=> (idx == $past(idx) + 1'b1)); // R3
   AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && last) |=> (idx == '0)); // R3
   AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IW'(LEN - 1)); // R9

endmodule

// File: rtl/tqp_ctrl.sv
module tqp_ctrl
   import tqp_pkg::*;
#(
   parameter bit EARLY_EXIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         c2b_is_cand,
   input  logic         b2c_is_origin,
   input  logic         a_last,
   input  logic         b_last,
   input  logic         c_last,
   output probe_state_t state,
   output logic         accept,
   output logic         step_a,
   output logic         step_b,
   output logic         step_c,
   output logic         ld_k,
   output logic         ld_l,
   output logic         busy,
   output logic         done,
   output logic         found
);

   probe_state_t state_nxt;
   logic         hit;
   logic         stop_hit;

   if (EARLY_EXIT) begin : g_stop_first
      assign stop_hit = c2b_is_cand;
   end else begin : g_walk_all
      assign stop_hit = 1'b0;
   end

   always_comb begin
      state_nxt = state;
      accept    = 1'b0;
      step_a    = 1'b0;
      step_b    = 1'b0;
      step_c    = 1'b0;
      ld_k      = 1'b0;
      ld_l      = 1'b0;
      hit       = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               accept    = 1'b1;
               state_nxt = ST_K_REQ;
            end
         end
         ST_K_REQ: state_nxt = ST_K_USE;
         ST_K_USE: begin
            if (c2b_is_cand) begin
               step_a    = 1'b1;
               state_nxt = a_last ? ST_DONE : ST_K_REQ;
            end else begin
               ld_k      = 1'b1;
               state_nxt = ST_L_REQ;
            end
         end
         ST_L_REQ: state_nxt = ST_L_USE;
         ST_L_USE: begin
            if (b2c_is_origin) begin
               step_b = 1'b1;
               if (b_last) begin
                  step_a    = 1'b1;
                  state_nxt = a_last ? ST_DONE : ST_K_REQ;
               end else begin
                  state_nxt = ST_L_REQ;
               end
            end else begin
               ld_l      = 1'b1;
               state_nxt = ST_M_REQ;
            end
         end
         ST_M_REQ: state_nxt = ST_M_USE;
         ST_M_USE: begin
            hit = c2b_is_cand;
            if (stop_hit) begin
               state_nxt = ST_DONE;
            end else begin
               step_c = 1'b1;
               if (!c_last) begin
                  state_nxt = ST_M_REQ;
               end else begin
                  step_b = 1'b1;
                  if (!b_last) begin
                     state_nxt = ST_L_REQ;
                  end else begin
                     step_a    = 1'b1;
                     state_nxt = a_last ? ST_DONE : ST_K_REQ;
                  end
               end
            end
         end
         ST_DONE: state_nxt = ST_IDLE;
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         found <= 1'b0;
      end else begin
         state <= state_nxt;
         if (accept)   found <= 1'b0;
         else if (hit) found <= 1'b1;
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_DONE);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy); // R2
   AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy); // R2
   AST_IDLE_FOUND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(found)); // R7
   AST_HIT_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (EARLY_EXIT && $rose(found)) |-> done); // R6

endmodule

// File: rtl/tanner_quad_probe.sv
module tanner_quad_probe
   import tqp_pkg::*;
#(
   parameter  int NUM_BITS   = 1024,
   parameter  int NUM_CHECKS = 512,
   parameter  int CHK_DEG    = 6,
   parameter  int BIT_DEG    = 3,
   parameter  bit EARLY_EXIT = 1'b1,
   localparam int BW  = idx_bits(NUM_BITS),
   localparam int CW  = idx_bits(NUM_CHECKS),
   localparam int SBW = idx_bits(CHK_DEG),
   localparam int SCW = idx_bits(BIT_DEG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BW-1:0]     cand_bit,
   input  logic [CW-1:0]     cand_chk,
   output logic              busy,
   output logic              done,
   output logic              loop_found,
   output logic [CW+SBW-1:0] c2b_addr,
   input  logic [BW-1:0]     c2b_data,
   output logic [BW+SCW-1:0] b2c_addr,
   input  logic [CW-1:0]     b2c_data
);

   if (NUM_BITS < 2 || NUM_CHECKS < 2) begin : g_bad_nodes
      $error("tanner_quad_probe: node counts must be at least 2");
   end
   if (CHK_DEG < 2 || BIT_DEG < 2) begin : g_bad_deg
      $error("tanner_quad_probe: degrees must be at least 2");
   end

   probe_state_t   state;
   logic           accept;
   logic           step_a, step_b, step_c;
   logic           ld_k, ld_l;
   logic           a_last, b_last, c_last;
   logic [SBW-1:0] a_idx;
   logic [SCW-1:0] b_idx;
   logic [SBW-1:0] c_idx;
   logic [BW-1:0]  tgt_bit;
   logic [CW-1:0]  tgt_chk;
   logic [BW-1:0]  k_reg;
   logic [CW-1:0]  l_reg;
   logic           c2b_is_cand;
   logic           b2c_is_origin;

   // Candidate pair and the two walk registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_bit <= '0;
         tgt_chk <= '0;
         k_reg   <= '0;
         l_reg   <= '0;
      end else begin
         if (accept) begin
            tgt_bit <= cand_bit;
            tgt_chk <= cand_chk;
         end
         if (ld_k) k_reg <= c2b_data;
         if (ld_l) l_reg <= b2c_data;
      end
   end

   assign c2b_is_cand   = (c2b_data == tgt_bit);
   assign b2c_is_origin = (b2c_data == tgt_chk);

   // Outer and inner loops share the check-to-bit port.
   always_comb begin
      if (state == ST_M_REQ || state == ST_M_USE)
         c2b_addr = {l_reg, c_idx};
      else
         c2b_addr = {tgt_chk, a_idx};
   end
   assign b2c_addr = {k_reg, b_idx};

   tqp_slot_ctr #(.LEN(CHK_DEG)) u_ctr_a (
      .clk(clk), .rst_n(rst_n), .clr(accept), .step(step_a),
      .idx(a_idx), .last(a_last));

   tqp_slot_ctr #(.LEN(BIT_DEG)) u_ctr_b (
      .clk(clk), .rst_n(rst_n), .clr(accept), .step(step_b),
      .idx(b_idx), .last(b_last));

   tqp_slot_ctr #(.LEN(CHK_DEG)) u_ctr_c (
      .clk(clk), .rst_n(rst_n), .clr(accept), .step(step_c),
      .idx(c_idx), .last(c_last));

   tqp_ctrl #(.EARLY_EXIT(EARLY_EXIT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .c2b_is_cand(c2b_is_cand), .b2c_is_origin(b2c_is_origin),
      .a_last(a_last), .b_last(b_last), .c_last(c_last),
      .state(state), .accept(accept),
      .step_a(step_a), .step_b(step_b), .step_c(step_c),
      .ld_k(ld_k), .ld_l(ld_l),
      .busy(busy), .done(done), .found(loop_found));

   AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(tgt_bit) && $stable(tgt_chk))); // R8
   AST_K_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_K_USE && c2b_is_cand) |=> (state != ST_L_REQ)); // R4
   AST_L_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_L_USE && b2c_is_origin) |=> (state != ST_M_REQ)); // R5
   AST_M_READS_L: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_M_REQ) |-> (c2b_addr[CW+SBW-1:SBW] == l_reg)); // R9

endmodule

// File: tb/tanner_quad_probe_bench.sv
`timescale 1ns/1ps
module tanner_quad_probe_bench;

   localparam int NB = 16;
   localparam int NC = 8;
   localparam int NV = 10;
   // Vector fields: seed [31:16], mode [9:8], cand bit [7:4], cand check [2:0]
   // mode 0 random, 1 random with cand bit scrubbed, 2 exclusion trap, 3 last-slot hit
   localparam logic [31:0] VEC [NV] = '{
      32'hACE1_0075, 32'h1234_00F0, 32'hBEEF_0023, 32'h0F0F_0096,
      32'h7777_00C1, 32'h5A5A_01A4, 32'h3C3C_0137, 32'h9999_0253,
      32'h4242_02E0, 32'h6B6B_0342 };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] cand_bit = '0;
   logic [2:0] cand_chk = '0;
   logic       busy, done, loop_found;
   logic [5:0] c2b_addr;
   logic [3:0] c2b_data;
   logic [5:0] b2c_addr;
   logic [2:0] b2c_data;

   logic [3:0] c2b_mem [64];
   logic [2:0] b2c_mem [64];

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      c2b_data <= c2b_mem[c2b_addr];
      b2c_data <= b2c_mem[b2c_addr];
   end

   tanner_quad_probe #(.NUM_BITS(NB), .NUM_CHECKS(NC)) u_tanner_quad_probe (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cand_bit(cand_bit), .cand_chk(cand_chk),
      .busy(busy), .done(done), .loop_found(loop_found),
      .c2b_addr(c2b_addr), .c2b_data(c2b_data),
      .b2c_addr(b2c_addr), .b2c_data(b2c_data));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic fill(input int seed, input int mode, input int ib, input int jc);
      logic [31:0] s;
      int fb, c0;
      s  = 32'(seed);
      fb = (ib + 1) % NB;
      c0 = (jc + 1) % NC;
      for (int x = 0; x < 64; x++) begin
         s = s * 32'd1103515245 + 32'd12345;
         c2b_mem[x] = s[19:16];
         s = s * 32'd1103515245 + 32'd12345;
         b2c_mem[x] = s[18:16];
      end
      if (mode == 1) begin
         for (int x = 0; x < 64; x++)
            if (int'(c2b_mem[x]) == ib) c2b_mem[x] = 4'(fb);
      end else if (mode >= 2) begin
         for (int x = 0; x < 64; x++) begin
            c2b_mem[x] = 4'(fb);
            b2c_mem[x] = 3'(jc);
         end
         if (mode == 2) begin
            c2b_mem[jc*8] = 4'(ib);
            for (int c = 0; c < 6; c++) c2b_mem[c0*8+c] = 4'(ib);
            for (int b = 0; b < 3; b++) b2c_mem[ib*4+b] = 3'(c0);
         end else begin
            for (int a = 0; a < 5; a++) c2b_mem[jc*8+a] = 4'(ib);
            b2c_mem[fb*4+2] = 3'(c0);
            c2b_mem[c0*8+5] = 4'(ib);
         end
      end
   endtask

   // Independent walk of the neighbourhood: flag and number of reads.
   task automatic model(input int ib, input int jc, output bit f, output int reads);
      f = 1'b0;
      reads = 0;
      for (int a = 0; a < 6 && !f; a++) begin
         int k;
         k = int'(c2b_mem[jc*8+a]);
         reads++;
         if (k == ib) continue;
         for (int b = 0; b < 3 && !f; b++) begin
            int l;
            l = int'(b2c_mem[k*4+b]);
            reads++;
            if (l == jc) continue;
            for (int c = 0; c < 6 && !f; c++) begin
               reads++;
               if (int'(c2b_mem[l*8+c]) == ib) f = 1'b1;
            end
         end
      end
   endtask

   task automatic wait_done(inout int lat, inout bit busy_ok);
      while (!done && lat < 2000) begin
         @(negedge clk);
         lat++;
         if (!done && !busy) busy_ok = 1'b0;
      end
      chk(done == 1'b1, "R3", "done within limit", int'(done), 1);
   endtask

   task automatic run_probe(input int ib, input int jc, output bit got,
                            output int lat, output bit busy_ok, output bit fc);
      @(negedge clk);
      start    = 1'b1;
      cand_bit = 4'(ib);
      cand_chk = 3'(jc);
      @(negedge clk);
      start   = 1'b0;
      lat     = 1;
      busy_ok = busy;
      fc      = loop_found;
      wait_done(lat, busy_ok);
      got = loop_found;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit got, ef, busy_ok, fc;
      int lat, er, seed, mode, ib, jc;

      for (int x = 0; x < 64; x++) begin
         c2b_mem[x] = '0;
         b2c_mem[x] = '0;
      end

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
      chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
      chk(loop_found == 1'b0, "R1", "flag in reset", int'(loop_found), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset",
          int'({busy, done}), 0);

      // Vector table walk
      for (int v = 0; v < NV; v++) begin
         seed = int'(VEC[v][31:16]);
         mode = int'(VEC[v][9:8]);
         ib   = int'(VEC[v][7:4]);
         jc   = int'(VEC[v][2:0]);
         fill(seed, mode, ib, jc);
         model(ib, jc, ef, er);
         run_probe(ib, jc, got, lat, busy_ok, fc);
         chk(got == ef, "R6 R9", "loop flag", int'(got), int'(ef));
         chk(lat == 2*er + 1, "R3", "latency", lat, 2*er + 1);
         chk(busy_ok, "R2", "busy through walk", int'(busy_ok), 1);
         chk(fc == 1'b0, "R7", "flag cleared on accept", int'(fc), 0);
         if (mode == 1)
            chk(got == 1'b0, "R6", "scrubbed bit gives no loop", int'(got), 0);
         if (mode == 2) begin
            chk(got == 1'b0, "R4 R5", "skipped nodes give no loop", int'(got), 0);
            chk(lat == 43, "R4 R5", "skipped lists not read", lat, 43);
         end
         if (mode == 3) begin
            chk(got == 1'b1, "R6", "last-slot match", int'(got), 1);
            chk(lat == 31, "R3", "last-slot latency", lat, 31);
         end
         @(negedge clk);
         chk(done == 1'b0, "R7", "done single pulse", int'(done), 0);
         chk(busy == 1'b0, "R2", "busy low after done", int'(busy), 0);
         repeat (3) @(negedge clk);
         chk(loop_found == ef, "R7", "flag held", int'(loop_found), int'(ef));
      end

      // R8: start while busy and during the done cycle
      fill(16'h2468, 0, 2, 6);
      model(2, 6, ef, er);
      @(negedge clk);
      start    = 1'b1;
      cand_bit = 4'd2;
      cand_chk = 3'd6;
      @(negedge clk);
      start   = 1'b0;
      lat     = 1;
      busy_ok = busy;
      @(negedge clk);
      lat++;
      start    = 1'b1;
      cand_bit = 4'd11;
      cand_chk = 3'd1;
      @(negedge clk);
      lat++;
      start = 1'b0;
      wait_done(lat, busy_ok);
      chk(lat == 2*er + 1, "R8", "latency unchanged by busy start", lat, 2*er + 1);
      chk(loop_found == ef, "R8", "flag unchanged by busy start",
          int'(loop_found), int'(ef));
      start = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R8", "start in done cycle ignored", int'(busy), 0);
      chk(loop_found == ef, "R8", "flag kept after done-cycle start",
          int'(loop_found), int'(ef));
      start = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R8", "stays idle",
          int'({busy, done}), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule